// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter whose register changes only on the rising clock edge. Each edge does one of three things. It captures a parallel preset word, or it steps the stored value up or down by one, or it keeps the value as it is. A direction input picks whether a step adds or subtracts one. The count wraps around modulo 2^WIDTH, so with the default width of 4 it wraps modulo 16.

Stepping needs two active-low enables at once. The shared enable goes to every stage of a chain. The ripple enable comes from the previous stage's terminal-count flag. The terminal-count output is a combinational decode. It goes low when the ripple enable is low and the stored value sits at the end of the range for the selected direction. That end is all ones when counting up and zero when counting down.

To build a wider counter, connect each stage's terminal-count flag to the ripple enable of the next stage. All stages share one clock, one shared enable, one load and one direction input. The flag is decoded from register state, so it can glitch. It is meant only as an enable and never as a clock.

Top module: `updn_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 on that edge.
- R2: When `load_n` is low at a rising edge, `q` takes the value of `din` on that edge.
- R3: A load wins over counting. With `load_n` low, `q` becomes `din` even when both count enables are low.
- R4: With `load_n` high, both `cnt_en_n` and `chain_en_n` low and `up` = 1, `q` increases by one on the edge.
- R5: Under the same enable conditions with `up` = 0, `q` decreases by one on the edge.
- R6: Counting wraps. Counting up goes from 15 to 0, and counting down goes from 0 to 15 (default WIDTH = 4).
- R7: With `load_n` high and either `cnt_en_n` or `chain_en_n` high, `q` keeps its value.
- R8: `tc_n` is 0 exactly when `chain_en_n` is 0 and either `up` = 1 with `q` = 15, or `up` = 0 with `q` = 0. In every other case it is 1.
- R9: `tc_n` does not depend on `cnt_en_n`.
- R10: `tc_n` is combinational. It follows a change of `up` or `chain_en_n` within the same clock period, with no edge needed.
- R11: Three stages chained through `tc_n` into `chain_en_n` behave as one 12-bit counter. They load, count up and down with wrap across the stage boundaries, and hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset to zero, active low |
| load_n | input | 1 | Preset enable, active low |
| din | input | WIDTH | Preset value |
| cnt_en_n | input | 1 | Shared count enable, active low |
| chain_en_n | input | 1 | Ripple count enable, active low; also gates `tc_n` |
| up | input | 1 | Direction: 1 up, 0 down |
| q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
Register results (reset, load, step, hold) are due on the first rising edge after the inputs are applied. The driver applies each stimulus on a falling edge and queues the post-edge value. The monitor then reads `q` and the chained 12-bit value 5 ns after the next rising edge. The terminal-count flag has no latency. It is checked 2 ns after each stimulus change, before the edge, against the value still held in the register. For the checks that hold the count steady while only the enables or the direction change, the driver reloads the current value.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

    parameter int DEFAULT_WIDTH = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;

endpackage

// File: rtl/updn_mode_sel.sv
`timescale 1ns/1ps
module updn_mode_sel
    import updn_pkg::*;
(
    input  logic load_n,
    input  logic cnt_en_n,
    input  logic chain_en_n,
    input  logic up,
    output op_e  op
);

    logic step_ok;

    always_comb begin
        step_ok = ~cnt_en_n & ~chain_en_n;
        if (!load_n) begin
            op = OP_LOAD;            // preset has priority
        end else if (step_ok) begin
            op = up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/updn_next.sv
`timescale 1ns/1ps
module updn_next
    import updn_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = preset;
            OP_INC:  nxt = cur + ONE;   // natural wrap at all ones
            OP_DEC:  nxt = cur - ONE;   // natural wrap at zero
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_tc_dec.sv
`timescale 1ns/1ps
module updn_tc_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             chain_en_n,
    output logic             tc_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_top;
    logic at_bottom;
    logic at_end;

    always_comb begin
        at_top    = (cur == TOP);
        at_bottom = (cur == '0);
        at_end    = up ? at_top : at_bottom;
        tc_n      = ~(at_end & ~chain_en_n);
    end

endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter
    import updn_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic             up,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] STEP     = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    op_e              op;
    logic [WIDTH-1:0] nxt_cnt;

    updn_mode_sel u_sel (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .up         (up),
        .op         (op)
    );

    updn_next #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .cur    (st_q.cnt),
        .preset (din),
        .nxt    (nxt_cnt)
    );

    updn_tc_dec #(.WIDTH(WIDTH)) u_tc (
        .cur        (st_q.cnt),
        .up         (up),
        .chain_en_n (chain_en_n),
        .tc_n       (tc_n)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = nxt_cnt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    // R2
    load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    // R3
    load_beats_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !cnt_en_n && !chain_en_n) |=> q == $past(din));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && up) |=> q == $past(q) + STEP);

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !up) |=> q == $past(q) - STEP);

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && up && q == ALL_ONES) |=> q == '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q));

    // R8
    tc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en_n |-> tc_n);

    // R8
    tc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en_n && up && q == ALL_ONES) |-> !tc_n);

    // R8
    tc_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q != ALL_ONES && q != '0) |-> tc_n);

endmodule

// File: tb/sim_updn_counter.sv
`timescale 1ns/1ps
module sim_updn_counter;

    localparam int W      = 4;
    localparam int NST    = 3;
    localparam int CW     = W * NST;
    localparam int WD_CYC = 200000;

    typedef struct {
        logic [W-1:0]  q;
        logic [CW-1:0] cq;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic [W-1:0]  din = '0;
    logic [CW-1:0] cdin = '0;
    logic          cep = 1'b1;
    logic          tet = 1'b1;
    logic          up = 1'b1;
    logic [W-1:0]  q;
    logic          tc_n;

    logic [W-1:0]  c_q  [NST];
    logic [NST-1:0] c_tc_n;
    logic [NST-1:0] c_te_n;
    logic [CW-1:0] cq_all;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    logic [W-1:0]  m_q  = '0;
    logic [CW-1:0] m_cq = '0;

    always #10 clk = ~clk;   // 50 MHz

    updn_counter #(.WIDTH(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .din        (din),
        .cnt_en_n   (cep),
        .chain_en_n (tet),
        .up         (up),
        .q          (q),
        .tc_n       (tc_n)
    );

    for (genvar k = 0; k < NST; k++) begin : g_chain
        if (k == 0) begin : g_first
            assign c_te_n[k] = tet;
        end else begin : g_rest
            assign c_te_n[k] = c_tc_n[k-1];
        end
        updn_counter #(.WIDTH(W)) u_st (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_n     (load_n),
            .din        (cdin[k*W +: W]),
            .cnt_en_n   (cep),
            .chain_en_n (c_te_n[k]),
            .up         (up),
            .q          (c_q[k]),
            .tc_n       (c_tc_n[k])
        );
        assign cq_all[k*W +: W] = c_q[k];
    end

    function automatic logic exp_tc(input logic [W-1:0] v, input logic te, input logic u);
        logic hit;
        hit = u ? (v == {W{1'b1}}) : (v == '0);
        return !(hit && !te);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: apply on falling edge, check combinational flag, queue post-edge values
    task automatic step(input logic ld, input logic [W-1:0] d, input logic [CW-1:0] cd,
                        input logic ce, input logic te, input logic u, input string tag);
        exp_t e;
        @(negedge clk);
        load_n = ld; din = d; cdin = cd; cep = ce; tet = te; up = u;
        #2;
        chk(tc_n === exp_tc(m_q, te, u), tag, "tc_n pre-edge",
            CW'(tc_n), CW'(exp_tc(m_q, te, u)));
        if (!rst_n) begin
            m_q = '0; m_cq = '0;
        end else if (!ld) begin
            m_q = d; m_cq = cd;
        end else if (!ce && !te) begin
            m_q  = u ? m_q + 1'b1  : m_q - 1'b1;
            m_cq = u ? m_cq + 1'b1 : m_cq - 1'b1;
        end
        e.q = m_q; e.cq = m_cq; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(q === e.q, e.tag, "q", CW'(q), CW'(e.q));
                chk(cq_all === e.cq, e.tag, "chain value", cq_all, e.cq);
            end
        end
    end

    initial begin
        // R1 reset
        rst_n = 1'b0;
        step(1'b1, 4'd0, '0, 1'b1, 1'b1, 1'b1, "R1");
        step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R2 preset
        step(1'b0, 4'd5, 12'h3A5, 1'b1, 1'b1, 1'b1, "R2");
        // R3 load priority with both enables low
        step(1'b0, 4'd9, 12'h7C9, 1'b0, 1'b0, 1'b1, "R3");
        // R4 count up
        for (int i = 0; i < 3; i++) step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b1, "R4");
        // R6 up wrap through 15
        step(1'b0, 4'd14, 12'h00E, 1'b1, 1'b1, 1'b1, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b1, "R6");
        // R5 count down, R6 down wrap through 0
        step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R5");
        // R7 hold on either enable high
        step(1'b1, 4'd3, '0, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 4'd3, '0, 1'b0, 1'b1, 1'b0, "R7");
        step(1'b1, 4'd3, '0, 1'b1, 1'b1, 1'b1, "R7");
        // R8 terminal decode at both ends
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b1, 1'b1, "R8");
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b0, 1'b1, "R8");
        step(1'b0, 4'd0, 12'h000, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 4'd0, 12'h000, 1'b1, 1'b0, 1'b1, "R8");
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b1, 1'b1, "R8");
        // R9 shared enable toggled at value 15, ripple enable low
        step(1'b0, 4'd15, 12'h00F, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 4'd15, 12'h00F, 1'b0, 1'b0, 1'b1, "R9");
        // R10 flag follows direction and ripple enable without a count
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b0, 1'b1, "R10");
        step(1'b0, 4'd15, 12'h00F, 1'b1, 1'b1, 1'b1, "R10");
        // R11 chained 12-bit counting across stage boundaries
        step(1'b0, 4'd0, 12'hFFE, 1'b1, 1'b1, 1'b1, "R11");
        for (int i = 0; i < 3; i++) step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b1, "R11");
        step(1'b0, 4'd0, 12'h0F1, 1'b1, 1'b1, 1'b0, "R11");
        for (int i = 0; i < 3; i++) step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R11");
        step(1'b0, 4'd0, 12'h002, 1'b1, 1'b1, 1'b0, "R11");
        for (int i = 0; i < 4; i++) step(1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, "R11");
        step(1'b1, 4'd0, '0, 1'b0, 1'b1, 1'b0, "R11");
        // drain
        @(negedge clk);
        load_n = 1'b1; cep = 1'b1; tet = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule